// File: doc/BRIEF.md
# Oversampled Transient Override PWM

This block drives one synchronous buck power stage. It produces complementary high-side and low-side gate commands from a duty word, a switching period and a dead time. All three are counted in clock cycles. It also reacts quickly to load transients. An external window comparator reports whether the output voltage has dropped below a lower limit or risen above an upper limit. The block samples those two flags at four evenly spaced points in every switching period. When a sample shows the output outside the window, the block changes the pulse in the period that is already running, without waiting for the next duty update.

A low sample means a load step has pulled the output down. The high-side command is then held on, or switched back on, up to a ceiling that still leaves room for the minimum low-side interval. A high sample means a load release has pushed the output up. The high-side pulse is then ended and the low-side switch takes over. Each switch from one gate to the other passes through the programmed dead interval. A one-cycle event pulse marks the start of each override, so that overrides can be counted.

Top module: `ovs_pwm`

## Requirements
- R1: While `rst_ni` is low, and from the second clock edge after `en_i` is sampled low, both gates and both event outputs are low.
- R2: Counts in a period run from 0 to P-1, where P is the latched period. In a period without override, the high-side request holds for counts below L = min(D, CAP), where D is the latched duty. The first high-side pulse after enable lasts L cycles. Later pulses, each preceded by low-side conduction, last L-T-1 cycles, where T is the latched dead time.
- R3: The two gates are never high together. Whenever one gate turns off and the other is requested, both stay low for exactly T+1 cycles before the other gate turns on.
- R4: `period_i`, `duty_i` and `dead_i` are captured only at count 0 (and on enable). A change made during a period takes effect from the next period.
- R5: Any high-side request ends at count CAP = P - T - MIN_LOW. MIN_LOW is a parameter with a default of 4.
- R6: The comparator flags are sampled when the count equals k*floor(P/4), for k = 0..3. A sampled flag changes the request from the following count onward.
- R7: An over-limit sample (`ov_i` high) with `ovs_en_i` high removes the high-side request, so the low side takes over. `ov_evt_o` pulses for one cycle when this override begins.
- R8: An under-limit sample (`uv_i` high) with `ovs_en_i` high requests the high side from the next count until CAP. This extends the current pulse or starts a second pulse in the same period. `uv_evt_o` pulses for one cycle when this override begins.
- R9: An override ends in the cycle after its flag goes low, or at the last count of the period, whichever comes first. A flag that is still set is sampled again at count 0 of the next period, which raises a new event.
- R10: When both flags are high at a sample, the over-limit response wins and only `ov_evt_o` pulses.
- R11: While `ovs_en_i` is low, the flags are ignored: pulse widths follow R2 and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low turns both gates off |
| ovs_en_i | input | 1 | Enables the transient override |
| period_i | input | CNT_W | Switching period in cycles (at least 8) |
| duty_i | input | CNT_W | Normal high-side request length in counts |
| dead_i | input | DT_W | Dead time T; the gap is T+1 cycles |
| uv_i | input | 1 | Comparator: output below the lower limit |
| ov_i | input | 1 | Comparator: output above the upper limit |
| hs_o | output | 1 | High-side gate command |
| ls_o | output | 1 | Low-side gate command |
| uv_evt_o | output | 1 | One-cycle pulse when an under-limit override begins |
| ov_evt_o | output | 1 | One-cycle pulse when an over-limit override begins |

## Verification
The bench measures every high-side pulse width against values worked out from the requirements. Flags are raised just before a quarter-period or half-period sample point, so a design that mistimed its sample points, or waited for the next period, would report the normal width instead of the cut or extended one. A flag held across a period boundary must produce one event per period and a pulse capped at CAP. A design that let overrides run past the period end, or ignored the duty ceiling, would report a wider pulse or too few events. Further cases cover a flag released in the middle of a period (the extension must stop early), both flags set at once (the cut must win), overrides switched off (the widths must stay unchanged), a duty word changed in the middle of a period, and the exact length of the both-low gap for two dead times.

// File: rtl/ovs_pwm_pkg.sv
package ovs_pwm_pkg;
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_UV   = 2'd1,
    OVR_OV   = 2'd2
  } ovr_e;
endpackage

// File: rtl/ovs_cycle_ctr.sv
module ovs_cycle_ctr #(
  parameter int CNT_W    = 10,
  parameter int DT_W     = 6,
  parameter int SMP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DT_W-1:0]  dead_o,
  output logic             smp_o,
  output logic             last_o
);
  localparam int NSMP = 1 << SMP_LOG2;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic [DT_W-1:0]  dead_q;
  logic [CNT_W-1:0] step;
  logic [NSMP-1:0]  hit;

  assign last_o = run_q && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || last_o) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      per_q  <= period_i;
      duty_q <= duty_i;
      dead_q <= dead_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // evenly spaced sample points
  assign step = per_q >> SMP_LOG2;
  for (genvar k = 0; k < NSMP; k++) begin : g_smp
    assign hit[k] = (cnt_q == CNT_W'(k) * step);
  end

  assign smp_o  = run_q && (|hit);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign dead_o = dead_q;
endmodule

// File: rtl/ovs_override.sv
module ovs_override
  import ovs_pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ovs_en_i,
  input  logic smp_i,
  input  logic last_i,
  input  logic uv_i,
  input  logic ov_i,
  output ovr_e ovr_o,
  output logic uv_evt_o,
  output logic ov_evt_o
);
  ovr_e ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (!run_i || !ovs_en_i || last_i)   ovr_d = OVR_NONE;
    else if (smp_i && ov_i)              ovr_d = OVR_OV;  // over-limit wins
    else if (smp_i && uv_i)              ovr_d = OVR_UV;
    else if (ovr_q == OVR_OV && !ov_i)   ovr_d = OVR_NONE;
    else if (ovr_q == OVR_UV && !uv_i)   ovr_d = OVR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q    <= OVR_NONE;
      uv_evt_o <= 1'b0;
      ov_evt_o <= 1'b0;
    end else begin
      ovr_q    <= ovr_d;
      uv_evt_o <= (ovr_d == OVR_UV) && (ovr_q != OVR_UV);
      ov_evt_o <= (ovr_d == OVR_OV) && (ovr_q != OVR_OV);
    end
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/ovs_gate_dt.sv
module ovs_gate_dt #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            req_hs_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hs_o,
  output logic            ls_o
);
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      dt_q <= '0;
    end else if (!run_i) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      dt_q <= '0;
    end else if (req_hs_i) begin
      if (ls_o) begin
        ls_o <= 1'b0;
        dt_q <= dead_i;
      end else if (!hs_o) begin
        if (dt_q == '0) hs_o <= 1'b1;
        else            dt_q <= dt_q - 1'b1;
      end
    end else begin
      if (hs_o) begin
        hs_o <= 1'b0;
        dt_q <= dead_i;
      end else if (!ls_o) begin
        if (dt_q == '0) ls_o <= 1'b1;
        else            dt_q <= dt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovs_pwm.sv
module ovs_pwm
  import ovs_pwm_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DT_W     = 6,
  parameter int MIN_LOW  = 4,
  parameter int SMP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ovs_en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             uv_i,
  input  logic             ov_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic             uv_evt_o,
  output logic             ov_evt_o
);
  localparam int XW = CNT_W + 1;

  logic             run, smp, last;
  logic [CNT_W-1:0] cnt, per, duty;
  logic [DT_W-1:0]  dead;
  logic [XW-1:0]    cap_x;
  logic [CNT_W-1:0] cap, lim;
  logic             req_hs;
  ovr_e             ovr;

  ovs_cycle_ctr #(.CNT_W(CNT_W), .DT_W(DT_W), .SMP_LOG2(SMP_LOG2)) u_ctr (
    .clk_i, .rst_ni, .en_i, .period_i, .duty_i, .dead_i,
    .run_o(run), .cnt_o(cnt), .per_o(per), .duty_o(duty), .dead_o(dead),
    .smp_o(smp), .last_o(last)
  );

  ovs_override u_ovr (
    .clk_i, .rst_ni, .run_i(run), .ovs_en_i, .smp_i(smp), .last_i(last),
    .uv_i, .ov_i, .ovr_o(ovr), .uv_evt_o, .ov_evt_o
  );

  // ceiling keeps room for dead time plus minimum low-side interval
  assign cap_x = {1'b0, per} - XW'(dead) - XW'(MIN_LOW);
  assign cap   = cap_x[CNT_W] ? '0 : cap_x[CNT_W-1:0];
  assign lim   = (duty < cap) ? duty : cap;

  always_comb begin
    unique case (ovr)
      OVR_UV:  req_hs = run && (cnt < cap);
      OVR_OV:  req_hs = 1'b0;
      default: req_hs = run && (cnt < lim);
    endcase
  end

  ovs_gate_dt #(.DT_W(DT_W)) u_gate (
    .clk_i, .rst_ni, .run_i(run), .req_hs_i(req_hs), .dead_i(dead),
    .hs_o, .ls_o
  );
endmodule

// File: rtl/ovs_pwm_chk.sv
module ovs_pwm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic ovs_en_i,
  input logic hs_o,
  input logic ls_o,
  input logic uv_evt_o,
  input logic ov_evt_o
);
  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));

  // R3
  hs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(!ls_o));

  // R3
  ls_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) |-> !ls_o);

  // R7
  ov_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_evt_o |=> !hs_o);

  // R1
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |=> (!hs_o && !ls_o && !uv_evt_o && !ov_evt_o));

  // R11
  ovs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovs_en_i && $past(!ovs_en_i)) |-> (!uv_evt_o && !ov_evt_o));

  // R10
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uv_evt_o && ov_evt_o));
endmodule

bind ovs_pwm ovs_pwm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ovs_en_i(ovs_en_i),
  .hs_o(hs_o), .ls_o(ls_o), .uv_evt_o(uv_evt_o), .ov_evt_o(ov_evt_o)
);

// File: tb/ovs_pwm_tb_top.sv
`timescale 1ns/1ps
module ovs_pwm_tb_top;
  localparam int CNT_W = 10;
  localparam int DT_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ovs_en = 1'b0, uv = 1'b0, ov = 1'b0;
  logic [CNT_W-1:0] period = 10'd100, duty = '0;
  logic [DT_W-1:0]  dead = '0;
  logic hs, ls, uv_evt, ov_evt;

  int nchk = 0, nfail = 0;
  int ecnt = -1;
  int hw = 0, lowc = 0, last_gap = 0;
  int uv_cnt = 0, ov_cnt = 0;
  int cur_per = 100;
  bit done = 1'b0;
  string cur_req = "R2";
  int exp_q[$];

  always #2.5 clk = ~clk;

  ovs_pwm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ovs_en_i(ovs_en),
    .period_i(period), .duty_i(duty), .dead_i(dead),
    .uv_i(uv), .ov_i(ov), .hs_o(hs), .ls_o(ls),
    .uv_evt_o(uv_evt), .ov_evt_o(ov_evt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge count since the enabling edge: count value = ecnt % period
  always @(posedge clk) ecnt <= en ? ecnt + 1 : -1;

  // monitor: measure high-side pulses and pop the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs && ls) chk(1'b0, "R3", "gates overlap", 1, 0);
      if (hs) hw++;
      else if (hw > 0) begin
        if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected hs pulse", hw, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(hw == e, cur_req, "hs pulse width", hw, e);
        end
        hw = 0;
      end
      if (!hs && !ls) lowc++;
      else begin
        if (hs && lowc > 0) last_gap = lowc;
        lowc = 0;
      end
      if (uv_evt) uv_cnt++;
      if (ov_evt) ov_cnt++;
    end
  end

  task automatic wait_e(input int k);
    while (ecnt != k) @(negedge clk);
  endtask

  task automatic start(input int p, input int d, input int t, input bit oe,
                       input string req);
    @(negedge clk);
    en = 1'b0; uv = 1'b0; ov = 1'b0;
    repeat (4) @(negedge clk);
    period = CNT_W'(p); duty = CNT_W'(d); dead = DT_W'(t); ovs_en = oe;
    cur_per = p; cur_req = req;
    uv_cnt = 0; ov_cnt = 0;
    en = 1'b1;
  endtask

  task automatic finish(input int ncyc, input int exp_uv, input int exp_ov);
    wait_e(ncyc * cur_per - 1);
    en = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, "missing hs pulses", exp_q.size(), 0);
    exp_q.delete();
    chk(uv_cnt == exp_uv, cur_req, "uv events", uv_cnt, exp_uv);
    chk(ov_cnt == exp_ov, cur_req, "ov events", ov_cnt, exp_ov);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!hs && !ls && !uv_evt && !ov_evt, "R1", "outputs in reset",
        {hs, ls, uv_evt, ov_evt}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!hs && !ls, "R1", "gates while disabled", {hs, ls}, 0);

    // R2 R3: plain duty, T=3
    exp_q.push_back(40); exp_q.push_back(36); exp_q.push_back(36);
    start(100, 40, 3, 1'b1, "R2");
    finish(3, 0, 0);
    chk(last_gap == 4, "R3", "both-low gap T=3", last_gap, 4);

    // R3: T=6
    exp_q.push_back(40); exp_q.push_back(33);
    start(100, 40, 6, 1'b1, "R3");
    finish(2, 0, 0);
    chk(last_gap == 7, "R3", "both-low gap T=6", last_gap, 7);

    // R4: duty changed mid-period
    exp_q.push_back(40); exp_q.push_back(36); exp_q.push_back(66);
    start(100, 40, 3, 1'b1, "R4");
    wait_e(120); duty = 10'd70;
    finish(3, 0, 0);

    // R5: duty beyond ceiling 100-3-4=93
    exp_q.push_back(93); exp_q.push_back(89);
    start(100, 99, 3, 1'b1, "R5");
    finish(2, 0, 0);

    // R6 R7: over-limit seen at quarter sample (count 25)
    exp_q.push_back(60); exp_q.push_back(22); exp_q.push_back(56);
    start(100, 60, 3, 1'b1, "R7");
    wait_e(120); ov = 1'b1;
    wait_e(165); ov = 1'b0;
    finish(3, 0, 1);

    // R11: same stimulus with override off
    exp_q.push_back(60); exp_q.push_back(56); exp_q.push_back(56);
    start(100, 60, 3, 1'b0, "R11");
    wait_e(120); ov = 1'b1; uv = 1'b1;
    wait_e(165); ov = 1'b0; uv = 1'b0;
    finish(3, 0, 0);

    // R10: both flags, over-limit wins
    exp_q.push_back(60); exp_q.push_back(22); exp_q.push_back(56);
    start(100, 60, 3, 1'b1, "R10");
    wait_e(120); ov = 1'b1; uv = 1'b1;
    wait_e(165); ov = 1'b0; uv = 1'b0;
    finish(3, 0, 1);

    // R6 R8: under-limit seen at half sample, second pulse to ceiling
    exp_q.push_back(20); exp_q.push_back(16); exp_q.push_back(38); exp_q.push_back(16);
    start(100, 20, 3, 1'b1, "R8");
    wait_e(130); uv = 1'b1;
    wait_e(196); uv = 1'b0;
    finish(3, 1, 0);

    // R9: under-limit released mid-period ends the extension
    exp_q.push_back(20); exp_q.push_back(16); exp_q.push_back(16); exp_q.push_back(16);
    start(100, 20, 3, 1'b1, "R9");
    wait_e(130); uv = 1'b1;
    wait_e(170); uv = 1'b0;
    finish(3, 1, 0);

    // R9 R5: under-limit held over period boundaries
    exp_q.push_back(20); exp_q.push_back(89); exp_q.push_back(89); exp_q.push_back(16);
    start(100, 20, 3, 1'b1, "R9");
    wait_e(95); uv = 1'b1;
    wait_e(296); uv = 1'b0;
    finish(4, 2, 0);

    // R7 R9: over-limit held over period boundaries, no high-side pulse
    exp_q.push_back(40); exp_q.push_back(36);
    start(100, 40, 3, 1'b1, "R7");
    wait_e(95); ov = 1'b1;
    wait_e(296); ov = 1'b0;
    finish(4, 0, 2);

    // R1: disabled again
    chk(!hs && !ls, "R1", "gates after disable", {hs, ls}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule